// File: doc/BRIEF.md
# Single-Precision Underflow and Denormal Handler

This block sits at the tail of a single-precision floating-point pipe. It receives an unrounded result as a sign, a wide signed biased exponent and a normalised significand that carries one guard bit and one sticky bit. It also receives the rounding mode, the two trap enables for underflow and inexact, a flush-to-zero control, and the exponent and fraction fields of both source operands. One cycle later it returns the final 32-bit word, an emulation request, a trap request and two sticky exception flags.

The block does not build denormal results in hardware. A result that falls inside the denormal range is either replaced by a signed zero (flush mode) or handed to software through the emulation request. A denormal source operand always asks for emulation. Some results lie entirely below the smallest denormal. These are resolved in hardware to zero or to the smallest denormal, because that choice needs no shifter. Normal results are rounded in all four modes.

Each accepted result is sorted into one of six classes, and that class picks the output. The classes are K_OPND (a denormal operand), K_ZERO (an exact zero), K_NORM (a normal result), K_FLUSH (a tiny result with flush on), K_SUBMIN (a tiny result below the smallest denormal) and K_DENORM (a tiny result inside the denormal window). The class is chosen again for every accepted input, with no dependence on earlier inputs. The registered class moves K_IDLE→class on `valid_in` and class→K_IDLE when no input is accepted. The registered class is internal and is not visible at the ports.

Top module: `fpu_uf_handler`

## Requirements
- R1: Each result is registered. `valid_out` is high in the cycle after `valid_in` was high and low otherwise. `unimpl` and `trap_req` are low whenever `valid_out` is low.
- R2: Normal results (biased exponent ≥ 1) are rounded according to `rnd_mode`: 00 toward zero, 01 nearest-even, 10 toward +∞, 11 toward −∞. Only the guard and sticky bits decide an increment. The output word is {sign, exponent[7:0], fraction[22:0]}.
- R3: In nearest mode, an increment happens when guard=1 and (sticky=1 or fraction LSB=1), so ties go to even. A carry out of the fraction adds one to the exponent and leaves the fraction at zero.
- R4: For a normal result, the new inexact status equals guard OR sticky. A normal result never raises underflow.
- R5: The significand layout is [25] leading one, [24:2] fraction, [1] guard, [0] sticky. A result is tiny when its significand is nonzero and its biased exponent is ≤ 0. An all-zero significand gives a signed zero with no flags. Exponent 1 is normal.
- R6: A tiny result with exponent ≤ −23 and flush off rounds to a signed zero or to the signed smallest denormal (LSB set). Toward zero gives zero. +∞ mode goes up for positive values only, and −∞ mode goes up for negative values only. Nearest mode goes up only when the exponent is −23 and the fraction, guard or sticky bits are nonzero; an exact half goes to zero. Both underflow and inexact are set.
- R7: A tiny result with exponent −22..0 and flush off raises `unimpl` and outputs all zeros. It is inexact when any of the fraction bits that fall below the denormal LSB (the low 1−exponent bits), or guard or sticky, are set. Underflow = inexact OR `en_uf`.
- R8: With `flush_en`=1, every tiny result becomes a zero that keeps the result's sign. `unimpl` stays low, and both underflow and inexact are set.
- R9: An operand whose exponent field is 0 and whose fraction is nonzero raises `unimpl` and outputs all zeros, with no flag change and no trap. This holds regardless of `flush_en`. An operand with exponent 0 and fraction 0 is an ordinary zero and does not trigger this.
- R10: `trap_req` is high with an operation's output when that operation raises underflow with `en_uf`=1, or raises inexact with `en_ix`=1.
- R11: `flag_uf` and `flag_ix` accumulate across operations and are cleared by `flag_clr`. A flag raised in the same cycle as `flag_clr` survives. Without either event the flags hold.
- R12: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| valid_in | input | 1 | Result present this cycle |
| res_sign | input | 1 | Result sign |
| res_exp | input | 10 | Signed biased exponent of the unrounded result |
| res_sig | input | 26 | Leading one, 23 fraction bits, guard, sticky |
| rnd_mode | input | 2 | Rounding mode code |
| en_uf | input | 1 | Underflow trap enable |
| en_ix | input | 1 | Inexact trap enable |
| flush_en | input | 1 | Flush tiny results to zero |
| flag_clr | input | 1 | Clear pulse for the sticky flags |
| opa_exp | input | 8 | Operand A exponent field |
| opa_frac | input | 23 | Operand A fraction field |
| opb_exp | input | 8 | Operand B exponent field |
| opb_frac | input | 23 | Operand B fraction field |
| valid_out | output | 1 | Output word valid |
| res_out | output | 32 | Final result word |
| unimpl | output | 1 | Software emulation request |
| trap_req | output | 1 | Trap request for this operation |
| flag_uf | output | 1 | Sticky underflow flag |
| flag_ix | output | 1 | Sticky inexact flag |

## Verification
The assertions run on every cycle and cover the following:
- the one-cycle valid relation;
- the rule that emulation and trap requests never appear without a valid output;
- the holding and setting of the sticky flags;
- the rule that a trap never fires without a flag behind it;
- the signed-zero shape of flushed outputs;
- the trap suppression on a denormal operand.

Only the bench's scenarios can show that the numeric results are correct: the rounding in each mode and sign, tie-to-even and exponent carry, the choice between zero and the smallest denormal, the exactness mask in the denormal window, and the way the underflow flag follows its enable for an exact tiny result.

// File: rtl/fpu_uf_pkg.sv
package fpu_uf_pkg;

    typedef enum logic [1:0] {
        RM_ZERO = 2'b00,
        RM_NEAR = 2'b01,
        RM_UP   = 2'b10,
        RM_DOWN = 2'b11
    } rmode_e;

    typedef enum logic [2:0] {
        K_IDLE   = 3'd0,
        K_NORM   = 3'd1,
        K_ZERO   = 3'd2,
        K_SUBMIN = 3'd3,
        K_DENORM = 3'd4,
        K_FLUSH  = 3'd5,
        K_OPND   = 3'd6
    } kind_e;

endpackage

// File: rtl/fpu_uf_classify.sv
module fpu_uf_classify
    import fpu_uf_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int XW    = EXP_W + 2,
    localparam int SIG_W = FRAC_W + 3
) (
    input  logic signed [XW-1:0]     res_exp,
    input  logic        [SIG_W-1:0]  res_sig,
    input  logic                     flush_en,
    input  logic        [EXP_W-1:0]  opa_exp,
    input  logic        [FRAC_W-1:0] opa_frac,
    input  logic        [EXP_W-1:0]  opb_exp,
    input  logic        [FRAC_W-1:0] opb_frac,
    output kind_e                    kind,
    output logic                     window_lost
);

    localparam logic signed [XW-1:0] LO_EXP = XW'(-FRAC_W);

    logic              opa_den;
    logic              opb_den;
    logic [FRAC_W-1:0] lost_vec;

    // Fraction bit i drops below the denormal LSB when exponent <= -i.
    for (genvar i = 0; i < FRAC_W; i++) begin : g_lost
        localparam logic signed [XW-1:0] EDGE = XW'(-i);
        assign lost_vec[i] = res_sig[i+2] & (res_exp <= EDGE);
    end

    assign window_lost = (|lost_vec) | res_sig[1] | res_sig[0];

    always_comb begin
        opa_den = (opa_exp == '0) && (opa_frac != '0);
        opb_den = (opb_exp == '0) && (opb_frac != '0);
        if (opa_den || opb_den) begin
            kind = K_OPND;
        end else if (res_sig == '0) begin
            kind = K_ZERO;
        end else if (res_exp > XW'(signed'(0))) begin
            kind = K_NORM;
        end else if (flush_en) begin
            kind = K_FLUSH;
        end else if (res_exp <= LO_EXP) begin
            kind = K_SUBMIN;
        end else begin
            kind = K_DENORM;
        end
    end

endmodule

// File: rtl/fpu_uf_round.sv
module fpu_uf_round
    import fpu_uf_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int XW    = EXP_W + 2,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic                     sign,
    input  logic signed [XW-1:0]     res_exp,
    input  logic        [FRAC_W+1:0] low_sig,
    input  logic        [1:0]        rnd_mode,
    output logic        [W-1:0]      norm_word,
    output logic                     norm_inexact,
    output logic        [W-1:0]      submin_word
);

    localparam logic signed [XW-1:0] HALF_EXP = XW'(-FRAC_W);

    logic [FRAC_W-1:0] frac;
    logic              grd;
    logic              stk;
    logic              inc;
    logic [FRAC_W:0]   sum;
    logic [EXP_W-1:0]  exp_o;
    logic              up;
    logic              above_half;

    always_comb begin
        frac = low_sig[FRAC_W+1:2];
        grd  = low_sig[1];
        stk  = low_sig[0];
        unique case (rmode_e'(rnd_mode))
            RM_ZERO: inc = 1'b0;
            RM_NEAR: inc = grd & (stk | frac[0]);
            RM_UP:   inc = ~sign & (grd | stk);
            RM_DOWN: inc = sign & (grd | stk);
            default: inc = 1'b0;
        endcase
        sum          = {1'b0, frac} + (FRAC_W+1)'(inc);
        exp_o        = res_exp[EXP_W-1:0] + EXP_W'(sum[FRAC_W]);
        norm_word    = {sign, exp_o, sum[FRAC_W-1:0]};
        norm_inexact = grd | stk;

        above_half = (frac != '0) | grd | stk;
        unique case (rmode_e'(rnd_mode))
            RM_ZERO: up = 1'b0;
            RM_NEAR: up = (res_exp == HALF_EXP) & above_half;
            RM_UP:   up = ~sign;
            RM_DOWN: up = sign;
            default: up = 1'b0;
        endcase
        submin_word = {sign, {(W-2){1'b0}}, up};
    end

endmodule

// File: rtl/fpu_uf_flags.sv
module fpu_uf_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic clr,
    input  logic new_uf,
    input  logic new_ix,
    input  logic en_uf,
    input  logic en_ix,
    output logic flag_uf,
    output logic flag_ix,
    output logic trap_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_uf <= 1'b0;
            flag_ix <= 1'b0;
            trap_q  <= 1'b0;
        end else begin
            flag_uf <= (flag_uf & ~clr) | (fire & new_uf);
            flag_ix <= (flag_ix & ~clr) | (fire & new_ix);
            trap_q  <= fire & ((new_uf & en_uf) | (new_ix & en_ix));
        end
    end

    // R11: flags hold with neither a clear nor an operation
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !fire) |=> ($stable(flag_uf) && $stable(flag_ix)));

    // R11: a raised underflow is visible next cycle even against a clear
    p_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && new_uf) |=> flag_uf);

    // R10: a trap always has a flag behind it
    p_trap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_q |-> (flag_uf || flag_ix));

endmodule

// File: rtl/fpu_uf_handler.sv
module fpu_uf_handler
    import fpu_uf_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int XW    = EXP_W + 2,
    localparam int SIG_W = FRAC_W + 3,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid_in,
    input  logic                     res_sign,
    input  logic signed [XW-1:0]     res_exp,
    input  logic        [SIG_W-1:0]  res_sig,
    input  logic        [1:0]        rnd_mode,
    input  logic                     en_uf,
    input  logic                     en_ix,
    input  logic                     flush_en,
    input  logic                     flag_clr,
    input  logic        [EXP_W-1:0]  opa_exp,
    input  logic        [FRAC_W-1:0] opa_frac,
    input  logic        [EXP_W-1:0]  opb_exp,
    input  logic        [FRAC_W-1:0] opb_frac,
    output logic                     valid_out,
    output logic        [W-1:0]      res_out,
    output logic                     unimpl,
    output logic                     trap_req,
    output logic                     flag_uf,
    output logic                     flag_ix
);

    kind_e        kind;
    kind_e        kind_q;
    logic         window_lost;
    logic [W-1:0] norm_word;
    logic         norm_inexact;
    logic [W-1:0] submin_word;
    logic [W-1:0] nxt_word;
    logic         nxt_un;
    logic         nxt_uf;
    logic         nxt_ix;
    logic         un_q;

    fpu_uf_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
        .res_exp     (res_exp),
        .res_sig     (res_sig),
        .flush_en    (flush_en),
        .opa_exp     (opa_exp),
        .opa_frac    (opa_frac),
        .opb_exp     (opb_exp),
        .opb_frac    (opb_frac),
        .kind        (kind),
        .window_lost (window_lost)
    );

    fpu_uf_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_rnd (
        .sign         (res_sign),
        .res_exp      (res_exp),
        .low_sig      (res_sig[FRAC_W+1:0]),
        .rnd_mode     (rnd_mode),
        .norm_word    (norm_word),
        .norm_inexact (norm_inexact),
        .submin_word  (submin_word)
    );

    // Output selection by class
    always_comb begin
        nxt_word = '0;
        nxt_un   = 1'b0;
        nxt_uf   = 1'b0;
        nxt_ix   = 1'b0;
        unique case (kind)
            K_NORM: begin
                nxt_word = norm_word;
                nxt_ix   = norm_inexact;
            end
            K_ZERO: nxt_word = {res_sign, {(W-1){1'b0}}};
            K_FLUSH: begin
                nxt_word = {res_sign, {(W-1){1'b0}}};
                nxt_uf   = 1'b1;
                nxt_ix   = 1'b1;
            end
            K_SUBMIN: begin
                nxt_word = submin_word;
                nxt_uf   = 1'b1;
                nxt_ix   = 1'b1;
            end
            K_DENORM: begin
                nxt_un = 1'b1;
                nxt_uf = window_lost | en_uf;
                nxt_ix = window_lost;
            end
            K_OPND:  nxt_un = 1'b1;
            default: nxt_word = '0;
        endcase
    end

    // Class / output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
            res_out   <= '0;
            un_q      <= 1'b0;
            kind_q    <= K_IDLE;
        end else begin
            valid_out <= valid_in;
            un_q      <= valid_in & nxt_un;
            kind_q    <= valid_in ? kind : K_IDLE;
            if (valid_in) begin
                res_out <= nxt_word;
            end
        end
    end

    assign unimpl = un_q;

    fpu_uf_flags u_flg (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (valid_in),
        .clr     (flag_clr),
        .new_uf  (nxt_uf),
        .new_ix  (nxt_ix),
        .en_uf   (en_uf),
        .en_ix   (en_ix),
        .flag_uf (flag_uf),
        .flag_ix (flag_ix),
        .trap_q  (trap_req)
    );

    // R1: one-cycle latency
    p_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);

    // R1: no requests without a valid output
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> (!valid_out && !unimpl && !trap_req));

    // R8: flushed output is a signed zero with both flags
    p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && kind_q == K_FLUSH) |->
            (res_out[W-2:0] == '0 && !unimpl && flag_uf && flag_ix));

    // R9: denormal operand requests emulation without a trap
    p_opnd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && kind_q == K_OPND) |-> (unimpl && !trap_req && res_out == '0));

endmodule

// File: tb/tb_fpu_uf_handler.sv
module tb_fpu_uf_handler;

    typedef struct packed {
        logic        s;
        logic [9:0]  e;
        logic [25:0] m;
        logic [1:0]  rm;
        logic        euf;
        logic        eix;
        logic        fl;
        logic [1:0]  opd;
        logic [31:0] xr;
        logic        xun;
        logic        xtr;
        logic        xuf;
        logic        xix;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VT [NV] = '{
        '{1'b0, 10'd127, {1'b1, 23'h0, 2'b11},      2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h3F800000, 1'b0, 1'b0, 1'b0, 1'b1},
        '{1'b0, 10'd127, {1'b1, 23'h0, 2'b11},      2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 32'h3F800001, 1'b0, 1'b0, 1'b0, 1'b1},
        '{1'b1, 10'd127, {1'b1, 23'h0, 2'b11},      2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 32'hBF800000, 1'b0, 1'b0, 1'b0, 1'b1},
        '{1'b1, 10'd127, {1'b1, 23'h0, 2'b11},      2'd3, 1'b0, 1'b0, 1'b0, 2'd0, 32'hBF800001, 1'b0, 1'b0, 1'b0, 1'b1},
        '{1'b0, 10'd127, {1'b1, 23'h0, 2'b10},      2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h3F800000, 1'b0, 1'b0, 1'b0, 1'b1},
        '{1'b0, 10'd127, {1'b1, 23'h1, 2'b10},      2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h3F800002, 1'b0, 1'b0, 1'b0, 1'b1},
        '{1'b0, 10'd127, {1'b1, 23'h7FFFFF, 2'b10}, 2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h40000000, 1'b0, 1'b0, 1'b0, 1'b1},
        '{1'b0, 10'd127, {1'b1, 23'h123456, 2'b00}, 2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h3F923456, 1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 10'd127, {1'b1, 23'h0, 2'b11},      2'd1, 1'b0, 1'b1, 1'b0, 2'd0, 32'h3F800001, 1'b0, 1'b1, 1'b0, 1'b1},
        '{1'b1, 10'd127, 26'h0,                     2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h80000000, 1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 10'h3E2, {1'b1, 23'h0, 2'b00},      2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h00000000, 1'b0, 1'b0, 1'b1, 1'b1},
        '{1'b0, 10'h3E2, {1'b1, 23'h0, 2'b00},      2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 32'h00000001, 1'b0, 1'b0, 1'b1, 1'b1},
        '{1'b1, 10'h3E2, {1'b1, 23'h0, 2'b00},      2'd3, 1'b0, 1'b0, 1'b0, 2'd0, 32'h80000001, 1'b0, 1'b0, 1'b1, 1'b1},
        '{1'b1, 10'h3E2, {1'b1, 23'h0, 2'b00},      2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 32'h80000000, 1'b0, 1'b0, 1'b1, 1'b1},
        '{1'b0, 10'h3E9, {1'b1, 23'h0, 2'b00},      2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h00000000, 1'b0, 1'b0, 1'b1, 1'b1},
        '{1'b0, 10'h3E9, {1'b1, 23'h1, 2'b00},      2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h00000001, 1'b0, 1'b0, 1'b1, 1'b1},
        '{1'b0, 10'h3E8, {1'b1, 23'h7FFFFF, 2'b11}, 2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h00000000, 1'b0, 1'b0, 1'b1, 1'b1},
        '{1'b0, 10'd0,   {1'b1, 23'h2, 2'b00},      2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h00000000, 1'b1, 1'b0, 1'b0, 1'b0},
        '{1'b0, 10'd0,   {1'b1, 23'h2, 2'b00},      2'd1, 1'b1, 1'b0, 1'b0, 2'd0, 32'h00000000, 1'b1, 1'b1, 1'b1, 1'b0},
        '{1'b0, 10'h3F6, {1'b1, 23'h400, 2'b00},    2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h00000000, 1'b1, 1'b0, 1'b1, 1'b1},
        '{1'b0, 10'h3EA, {1'b1, 23'h0, 2'b00},      2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h00000000, 1'b1, 1'b0, 1'b0, 1'b0},
        '{1'b1, 10'd0,   {1'b1, 23'h5, 2'b00},      2'd1, 1'b0, 1'b1, 1'b1, 2'd0, 32'h80000000, 1'b0, 1'b1, 1'b1, 1'b1},
        '{1'b0, 10'h3E2, {1'b1, 23'h0, 2'b00},      2'd2, 1'b0, 1'b0, 1'b1, 2'd0, 32'h00000000, 1'b0, 1'b0, 1'b1, 1'b1},
        '{1'b0, 10'd127, {1'b1, 23'h0, 2'b11},      2'd1, 1'b0, 1'b1, 1'b0, 2'd1, 32'h00000000, 1'b1, 1'b0, 1'b0, 1'b0},
        '{1'b0, 10'd127, {1'b1, 23'h0, 2'b11},      2'd1, 1'b0, 1'b1, 1'b1, 2'd2, 32'h00000000, 1'b1, 1'b0, 1'b0, 1'b0},
        '{1'b0, 10'd127, {1'b1, 23'h0, 2'b00},      2'd1, 1'b0, 1'b0, 1'b0, 2'd3, 32'h3F800000, 1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 10'd1,   {1'b1, 23'h0, 2'b00},      2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h00800000, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               valid_in = 1'b0;
    logic               res_sign = 1'b0;
    logic signed [9:0]  res_exp = '0;
    logic        [25:0] res_sig = '0;
    logic        [1:0]  rnd_mode = '0;
    logic               en_uf = 1'b0;
    logic               en_ix = 1'b0;
    logic               flush_en = 1'b0;
    logic               flag_clr = 1'b0;
    logic        [7:0]  opa_exp = 8'h7F;
    logic        [22:0] opa_frac = '0;
    logic        [7:0]  opb_exp = 8'h7F;
    logic        [22:0] opb_frac = '0;
    logic               valid_out;
    logic        [31:0] res_out;
    logic               unimpl;
    logic               trap_req;
    logic               flag_uf;
    logic               flag_ix;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    fpu_uf_handler dut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .res_sign(res_sign),
        .res_exp(res_exp), .res_sig(res_sig), .rnd_mode(rnd_mode),
        .en_uf(en_uf), .en_ix(en_ix), .flush_en(flush_en), .flag_clr(flag_clr),
        .opa_exp(opa_exp), .opa_frac(opa_frac), .opb_exp(opb_exp), .opb_frac(opb_frac),
        .valid_out(valid_out), .res_out(res_out), .unimpl(unimpl),
        .trap_req(trap_req), .flag_uf(flag_uf), .flag_ix(flag_ix)
    );

    function automatic string req_of(int i);
        if (i < 4)       return "R2";
        else if (i < 7)  return "R3";
        else if (i < 9)  return "R4/R10";
        else if (i < 10) return "R5";
        else if (i < 17) return "R6";
        else if (i < 21) return "R7";
        else if (i < 23) return "R8";
        else if (i < 26) return "R9";
        else             return "R5";
    endfunction

    task automatic check(input string req, input logic [36:0] got, input logic [36:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic clr);
        @(negedge clk);
        valid_in = 1'b1;
        flag_clr = clr;
        res_sign = v.s;
        res_exp  = v.e;
        res_sig  = v.m;
        rnd_mode = v.rm;
        en_uf    = v.euf;
        en_ix    = v.eix;
        flush_en = v.fl;
        opa_exp  = (v.opd == 2'd1 || v.opd == 2'd3) ? 8'h00 : 8'h7F;
        opa_frac = (v.opd == 2'd1) ? 23'h1 : 23'h0;
        opb_exp  = (v.opd == 2'd2 || v.opd == 2'd3) ? 8'h00 : 8'h7F;
        opb_frac = (v.opd == 2'd2) ? 23'h1 : 23'h0;
        @(negedge clk);
        valid_in = 1'b0;
        flag_clr = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    function automatic logic [36:0] outs();
        return {valid_out, res_out, unimpl, trap_req, flag_uf, flag_ix};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", outs(), 37'h0);
        rst_n = 1'b1;

        // Vector table, flags cleared before each
        for (int i = 0; i < NV; i++) begin
            pulse_clr();
            drive(VT[i], 1'b0);
            check(req_of(i), outs(),
                  {1'b1, VT[i].xr, VT[i].xun, VT[i].xtr, VT[i].xuf, VT[i].xix});
        end

        // R1: output drops one cycle after the last input
        @(negedge clk);
        check("R1", {33'h0, valid_out, unimpl, trap_req, 1'b0}, 37'h0);

        // R11: flags accumulate, hold, clear, and a same-cycle set survives
        pulse_clr();
        drive(VT[0], 1'b0);
        drive(VT[7], 1'b0);
        check("R11", {35'h0, flag_uf, flag_ix}, 37'h1);
        drive(VT[10], 1'b0);
        repeat (3) @(negedge clk);
        check("R11", {35'h0, flag_uf, flag_ix}, 37'h3);
        pulse_clr();
        check("R11", {35'h0, flag_uf, flag_ix}, 37'h0);
        drive(VT[0], 1'b1);
        check("R11", {35'h0, flag_uf, flag_ix}, 37'h1);

        // R9: ignored denormal operand leaves sticky flags untouched
        pulse_clr();
        drive(VT[23], 1'b0);
        check("R9", {35'h0, flag_uf, flag_ix}, 37'h0);

        // R10: trap only in the output cycle of the raising operation
        pulse_clr();
        drive(VT[8], 1'b0);
        @(negedge clk);
        check("R10", {36'h0, trap_req}, 37'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule